// File: doc/BRIEF.md
# Cascaded Delay-Line Serial Loader

This block writes the settings of a chain of ten delay-line devices that are connected in series on a three-pin serial link. The pins are a serial clock, a data line and a load strobe. The data output of each device drives the data input of the next one, so every write is one frame that passes through the whole chain. The frame carries one byte for each device. After the last bit, a strobe pulse makes all devices take their new bytes together.

When reset is released, the block sends a built-in set of default bytes without any request. After that, it sends the current contents of a parallel configuration word each time a start pulse arrives. Even a change to a single byte rewrites every device. A start pulse that arrives during a frame is remembered, and it triggers exactly one further frame when the current frame ends. A busy flag tells the host when the link is in use.

Top module: `dly_chain_loader`

## Requirements
- R1: After reset is released, the block sends the default frame 80'h09182736455463728190 without any start pulse. `busy_o` is high while reset is asserted and stays high until that frame has finished. Asserting reset in the middle of a frame abandons it, and the default frame is sent again after release.
- R2: Every frame has exactly 80 rising edges of `sclk_o` before its strobe pulse, which is eight bits for each of the ten devices.
- R3: Byte i of `cfg_i` sits at bits [8i+7:8i]. Byte 0 belongs to the device nearest the driver (data clock) and byte 9 to the farthest (reset clock). The fixed order between them is: data clock, second-channel SHP, first-channel SHP, second-channel SHD, first-channel SHD, H1A, H1B, H2A, H2B, reset clock. The frame sends byte 9 first and byte 0 last, each byte most significant bit first. The serial stream therefore equals `cfg_i` read from bit 79 down to bit 0.
- R4: One `sclk_o` period is DIV system cycles long, low for the first half and high for the second. `sdata_o` changes only while `sclk_o` is low and does not change while `sclk_o` is high.
- R5: `sload_o` stays low while bits are shifted. After the last bit it goes high for exactly DIV system cycles, and `sclk_o` is low during that pulse.
- R6: When the block is idle, a start pulse begins a frame that sends the value of `cfg_i` in the cycle the frame starts. All ten bytes are sent even if only one byte differs from the previous frame. A change to `cfg_i` during a frame does not alter that frame.
- R7: Any number of start pulses that arrive while `busy_o` is high cause exactly one further frame after the current frame. That frame sends the value of `cfg_i` in the cycle it starts.
- R8: `busy_o` is high from the cycle after an accepted start until the strobe pulse of the last owed frame has ended. While `busy_o` is low, `sclk_o`, `sdata_o` and `sload_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release triggers the default frame |
| start_i | input | 1 | One-cycle request to send the contents of `cfg_i` |
| cfg_i | input | N_DEV*DEV_W | Delay bytes, byte i for device i counted from the driver |
| busy_o | output | 1 | Frame in progress or owed |
| sclk_o | output | 1 | Serial clock to the chain |
| sdata_o | output | 1 | Serial data to the first device |
| sload_o | output | 1 | Strobe that latches all devices together |

## Verification
A bit counter that is off by one shows up at the pins at the next strobe pulse: the pulse arrives after 79 or 81 clock edges and every byte lands in the wrong device, at most one frame time (about 80·DIV cycles) after the error. A phase counter that skips a value breaks the clock period or moves a data change into the high half of `sclk_o`, and this is visible within one serial period. A lost pending flag shows up when the second frame fails to start. A flag that is never cleared shows up as an extra frame, and it is caught during the idle window that follows the frame.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } ld_state_e;
endpackage

// File: rtl/dly_sclk_phase.sv
module dly_sclk_phase #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o,
  output logic high_o
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (!run_i)          ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + 1'b1;
  end

  assign last_o = run_i && (ph_q == PH_LAST);
  assign high_o = run_i && (ph_q >= PH_HALF);
endmodule

// File: rtl/dly_frame_sreg.sv
module dly_frame_sreg #(
  parameter int W = 80
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= din_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/dly_load_fsm.sv
module dly_load_fsm
  import dly_pkg::*;
#(
  parameter int FRAME_W = 80
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      ph_last_i,
  output ld_state_e state_o,
  output logic      load_o,
  output logic      use_dflt_o,
  output logic      shift_o,
  output logic      run_o,
  output logic      busy_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(FRAME_W - 1);

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             dflt_q, pend_q, pend_d;
  logic             take_host;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (dflt_q || pend_q || start_i) begin
          load_o  = 1'b1;
          bit_d   = '0;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (ph_last_i) begin
          if (bit_q == BIT_LAST) state_d = ST_LATCH;
          else begin
            shift_o = 1'b1;
            bit_d   = bit_q + 1'b1;
          end
        end
      end
      ST_LATCH: if (ph_last_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // host request consumed only by a non-default frame
  assign take_host = load_o && !dflt_q;

  always_comb begin
    pend_d = pend_q;
    if (take_host) pend_d = 1'b0;
    if (start_i && !take_host) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      dflt_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      pend_q  <= pend_d;
      if (load_o) dflt_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign use_dflt_o = dflt_q;
  assign run_o      = (state_q != ST_IDLE);
  assign busy_o     = run_o || dflt_q || pend_q;
endmodule

// File: rtl/dly_chain_loader.sv
module dly_chain_loader
  import dly_pkg::*;
#(
  parameter int N_DEV = 10,
  parameter int DEV_W = 8,
  parameter int DIV   = 4,
  parameter logic [N_DEV*DEV_W-1:0] DEFAULTS = 80'h09182736455463728190
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [N_DEV*DEV_W-1:0] cfg_i,
  output logic                   busy_o,
  output logic                   sclk_o,
  output logic                   sdata_o,
  output logic                   sload_o
);
  localparam int FRAME_W = N_DEV * DEV_W;

  ld_state_e          state;
  logic               load, use_dflt, shift, run, ph_last, ph_high, msb;
  logic [FRAME_W-1:0] frame_src;

  dly_load_fsm #(.FRAME_W(FRAME_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ph_last_i  (ph_last),
    .state_o    (state),
    .load_o     (load),
    .use_dflt_o (use_dflt),
    .shift_o    (shift),
    .run_o      (run),
    .busy_o     (busy_o)
  );

  dly_sclk_phase #(.DIV(DIV)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .last_o (ph_last),
    .high_o (ph_high)
  );

  // farthest device byte sits in the top bits and leaves first
  assign frame_src = use_dflt ? DEFAULTS : cfg_i;

  dly_frame_sreg #(.W(FRAME_W)) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .din_i   (frame_src),
    .shift_i (shift),
    .msb_o   (msb)
  );

  assign sclk_o  = (state == ST_SHIFT) && ph_high;
  assign sdata_o = (state == ST_SHIFT) && msb;
  assign sload_o = (state == ST_LATCH);
endmodule

// File: rtl/dly_chain_loader_chk.sv
module dly_chain_loader_chk #(
  parameter int DIV     = 4,
  parameter int FRAME_W = 80
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic sload_o
);
  logic [15:0] ld_hi_cnt, sc_hi_cnt, rise_cnt;
  logic        sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_hi_cnt <= '0;
      sc_hi_cnt <= '0;
      rise_cnt  <= '0;
      sclk_q    <= 1'b0;
    end else begin
      sclk_q    <= sclk_o;
      ld_hi_cnt <= sload_o ? ld_hi_cnt + 1'b1 : '0;
      sc_hi_cnt <= sclk_o ? sc_hi_cnt + 1'b1 : '0;
      if (sload_o)                rise_cnt <= '0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_FRAME_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sload_o) |-> (rise_cnt == 16'(FRAME_W))); // R2
  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> (sc_hi_cnt == 16'(DIV / 2))); // R4
  AST_DATA_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o)); // R4
  AST_NO_CLK_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sload_o && sclk_o)); // R5
  AST_STROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sload_o) |-> (ld_hi_cnt == 16'(DIV))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sclk_o && !sload_o && !sdata_o)); // R8
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sload_o)); // R8
endmodule

bind dly_chain_loader dly_chain_loader_chk #(.DIV(DIV), .FRAME_W(FRAME_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_o  (busy_o),
  .sclk_o  (sclk_o),
  .sdata_o (sdata_o),
  .sload_o (sload_o)
);

// File: tb/tb_dly_chain_loader.sv
module tb_dly_chain_loader;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int FW  = 80;
  localparam logic [FW-1:0] DFLT = 80'h09182736455463728190;

  typedef struct packed {
    logic [FW-1:0] cfg;
    logic [FW-1:0] stream;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{cfg: 80'h0102030405060708090A, stream: 80'h0102030405060708090A},
    '{cfg: 80'h0102030405060708097A, stream: 80'h0102030405060708097A},
    '{cfg: 80'hFFFFFFFFFFFFFFFFFFFF, stream: 80'hFFFFFFFFFFFFFFFFFFFF},
    '{cfg: 80'h80000000000000000001, stream: 80'h80000000000000000001},
    '{cfg: 80'hA5C33C5A0FF0969600FF, stream: 80'hA5C33C5A0FF0969600FF}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [FW-1:0] cfg_i = '0;
  logic          busy_o, sclk_o, sdata_o, sload_o;
  int            n_cmp = 0;
  int            n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_chain_loader dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cfg_i   (cfg_i),
    .busy_o  (busy_o),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .sload_o (sload_o)
  );

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // decode one frame at the pins: bits, edge count, strobe width, bad periods
  task automatic grab(output logic [FW-1:0] bits, output int nb, output int ldw, output int pbad);
    logic p = 1'b0;
    int   t = 0;
    int   last = 0;
    bits = '0; nb = 0; ldw = 0; pbad = 0;
    do begin
      @(negedge clk);
      t++;
      if (sclk_o && !p) begin
        bits = {bits[FW-2:0], sdata_o};
        if (nb > 0 && (t - last) != DIV) pbad++;
        last = t;
        nb++;
      end
      p = sclk_o;
    end while (!sload_o);
    while (sload_o) begin
      ldw++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic frame_checks(input string tag, input logic [FW-1:0] exp);
    logic [FW-1:0] b;
    int nb, ldw, pbad;
    grab(b, nb, ldw, pbad);
    chk({tag, " stream"}, b, exp);
    chk("R2 edge count", FW'(nb), FW'(FW));
    chk("R5 strobe width", FW'(ldw), FW'(DIV));
    chk("R4 sclk period", FW'(pbad), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [FW-1:0] f1;
    int nb, ldw, pbad, extra;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 busy in reset", FW'(busy_o), FW'(1));
    chk("R8 pins low in reset", FW'({sclk_o, sload_o, sdata_o}), '0);
    cfg_i = 80'hDEADBEEFDEADBEEFDEAD;
    rst_ni = 1'b1;
    frame_checks("R1 default", DFLT);
    chk("R8 busy low after frame", FW'(busy_o), '0);

    // table of host frames (R3 order, R6 one-byte change)
    for (int i = 0; i < NV; i++) begin
      cfg_i = VEC[i].cfg;
      pulse_start();
      chk("R8 busy after start", FW'(busy_o), FW'(1));
      frame_checks("R3 R6 host", VEC[i].stream);
      chk("R8 idle after frame", FW'(busy_o), '0);
    end

    // R7: requests while busy coalesce into one extra frame; R6 mid-frame cfg change ignored
    cfg_i = 80'h11223344556677889900;
    pulse_start();
    fork
      grab(f1, nb, ldw, pbad);
      begin
        repeat (30) @(negedge clk);
        cfg_i = 80'hCAFEF00D123456789ABC;
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
      end
    join
    chk("R6 frame unaffected by cfg change", f1, 80'h11223344556677889900);
    chk("R7 busy held for pending", FW'(busy_o), FW'(1));
    frame_checks("R7 pending", 80'hCAFEF00D123456789ABC);
    chk("R7 busy low after pending", FW'(busy_o), '0);
    extra = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (sload_o || sclk_o || busy_o) extra++;
    end
    chk("R7 no second extra frame", FW'(extra), '0);

    // R1: reset mid-frame aborts and resends defaults
    cfg_i = 80'h5555555555555555AAAA;
    pulse_start();
    repeat (50) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 pins low in mid reset", FW'({sclk_o, sload_o, sdata_o}), '0);
    chk("R1 busy in mid reset", FW'(busy_o), FW'(1));
    rst_ni = 1'b1;
    frame_checks("R1 default after abort", DFLT);
    chk("R8 idle after default", FW'(busy_o), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule